// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Detect

This block works out the effective address of an operand for a byte-wide processor with a 16-bit address space. A start pulse launches it with an addressing mode, the two index registers and the address of the first operand byte. It then reads the operand bytes, and for the pointer modes the pointer bytes as well, through a byte-wide read port. It ends with a one-cycle done pulse while the effective address and a page-crossed flag are valid. Executing the instruction that uses the address is left to the surrounding core.

The read port has one cycle of latency: a byte requested with the read strobe in one cycle is on the data input in the next. The unit snapshots the mode, indexes, program counter and store hint when it accepts a start, so the core may change them while the unit works. Indexed modes that add with carry report when the high byte changes. For loads, the latency then grows by one clock. Indexed stores always take that extra clock.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is held, done, pageCross and memRd are 0 and effAddr is 0x0000.
- R2: After an accepted start, the first read is at pcIn and, for modes with a two-byte operand, the second is at pcIn+1. The byte at the lower address is the low byte. Read data is sampled the cycle after memRd.
- R3: Mode 0 (zero page) yields {0x00, LL} with pageCross 0. done comes 3 clocks after the start edge.
- R4: Modes 1 and 2 (zero page plus X, plus Y) yield {0x00, (LL+index) mod 256} with pageCross 0, in 3 clocks.
- R5: Mode 3 (absolute) yields {HH, LL} with pageCross 0, in 4 clocks, with or without the store hint.
- R6: Modes 4 and 5 (absolute plus X, plus Y) add the index to {HH, LL} with carry. pageCross is 1 exactly when the high byte changes. Latency is 4 clocks, plus 1 when pageCross is 1 or wrAccess was 1.
- R7: Mode 6 (indexed indirect) reads the pointer low byte at {0x00, (LL+X) mod 256} and the high byte at {0x00, (LL+X+1) mod 256}. It yields that word, pageCross 0, in 6 clocks.
- R8: Mode 7 (indirect indexed) reads the pointer at {0x00, LL} and {0x00, (LL+1) mod 256}. It adds Y with carry, and pageCross is 1 when the high byte changes. Latency is 6 clocks, plus 1 when pageCross is 1 or wrAccess was 1.
- R9: Mode 8 (absolute indirect) reads the target low byte at {HH, LL} and the high byte at {HH, LL}+1, with carry into HH. It yields that word, pageCross 0, in 7 clocks.
- R10: Mode 9 (relative) adds the sign-extended offset byte to pcIn+1. pageCross is 1 when the target's high byte differs from that of pcIn+1. Latency is 3 clocks.
- R11: done is high for exactly one clock. effAddr and pageCross change only in a cycle where done is high, and hold until the next done.
- R12: A start raised while an address is being formed is ignored. Changes to mode, indexes, pcIn or wrAccess after the start edge do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, accepted when the unit is idle |
| mode | input | 4 | Addressing mode code, 0 to 9 |
| wrAccess | input | 1 | Store hint: indexed carry modes always take the extra clock |
| idxX | input | 8 | X index value |
| idxY | input | 8 | Y index value |
| pcIn | input | 16 | Address of the first operand byte |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read strobe |
| memData | input | 8 | Read data, one cycle after the strobe |
| effAddr | output | 16 | Effective address, valid with done |
| pageCross | output | 1 | High byte changed by a carrying add |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with the default byte width of 8, so addresses are 16 bits. At this width, random operand and index bytes hit both the carrying and non-carrying cases of every indexed mode about equally often. Directed vectors place pointers and operands at 0xFF in page zero and at page ends. These cover wrap-around in page zero, carry into the high byte for absolute indirect, and relative branches that cross in both directions. Scrambled inputs and stray start pulses during each operation test the snapshot and ignore behaviour.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_IZX  = 4'd6,
    AM_IZY  = 4'd7,
    AM_IND  = 4'd8,
    AM_REL  = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    SEL_PC0  = 2'd0,
    SEL_PC1  = 2'd1,
    SEL_PTR0 = 2'd2,
    SEL_PTR1 = 2'd3
  } addr_sel_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic      loadCtx;
    logic      capOpLo;
    logic      capOpHi;
    logic      capWLo;
    logic      capWHi;
    logic      latchEa;
    logic      rdEn;
    addr_sel_e addrSel;
  } ctl_s;

endpackage

// File: rtl/eag_off_add.sv
module eag_off_add #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              signExt,
  output logic [ADDR_W-1:0] sum,
  output logic              crossed
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [EXT_W-1:0] extBits;

  assign extBits = (signExt && offset[DATA_W-1]) ? '1 : '0;
  assign sum     = base + {extBits, offset};
  assign crossed = sum[ADDR_W-1:DATA_W] != base[ADDR_W-1:DATA_W];
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              wrIn,
  input  logic              crossNow,
  output ctl_s              ctl,
  output amode_e            curMode
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_OPLO, ST_OPHI, ST_CAPL, ST_CAPH,
    ST_PLO, ST_PHI, ST_PCAP, ST_EVAL, ST_FIX
  } state_e;

  state_e state, nextState;
  amode_e modeR;
  logic   wrR;
  logic   twoByte, ptrShort, needFix;

  assign curMode  = modeR;
  assign twoByte  = modeR inside {AM_ABS, AM_ABSX, AM_ABSY, AM_IND};
  assign ptrShort = modeR inside {AM_IZX, AM_IZY};
  assign needFix  = (modeR inside {AM_ABSX, AM_ABSY, AM_IZY}) && (crossNow || wrR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      modeR <= AM_ZP;
      wrR   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        modeR <= amode_e'(modeIn);
        wrR   <= wrIn;
      end
    end
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.addrSel = SEL_PC0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadCtx = 1'b1;
          nextState   = ST_OPLO;
        end
      end
      ST_OPLO: begin
        ctl.rdEn    = 1'b1;
        ctl.addrSel = SEL_PC0;
        nextState   = twoByte ? ST_OPHI : ST_CAPL;
      end
      ST_OPHI: begin
        ctl.rdEn    = 1'b1;
        ctl.addrSel = SEL_PC1;
        ctl.capOpLo = 1'b1;
        nextState   = ST_CAPH;
      end
      ST_CAPL: begin
        ctl.capOpLo = 1'b1;
        nextState   = ptrShort ? ST_PLO : ST_EVAL;
      end
      ST_CAPH: begin
        ctl.capOpHi = 1'b1;
        nextState   = (modeR == AM_IND) ? ST_PLO : ST_EVAL;
      end
      ST_PLO: begin
        ctl.rdEn    = 1'b1;
        ctl.addrSel = SEL_PTR0;
        nextState   = ST_PHI;
      end
      ST_PHI: begin
        ctl.rdEn    = 1'b1;
        ctl.addrSel = SEL_PTR1;
        ctl.capWLo  = 1'b1;
        nextState   = ST_PCAP;
      end
      ST_PCAP: begin
        ctl.capWHi = 1'b1;
        nextState  = ST_EVAL;
      end
      ST_EVAL: begin
        if (needFix) begin
          nextState = ST_FIX;
        end else begin
          ctl.latchEa = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      ST_FIX: begin
        ctl.latchEa = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/eag_dpath.sv
module eag_dpath
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_s              ctl,
  input  amode_e            curMode,
  input  logic [DATA_W-1:0] idxX,
  input  logic [DATA_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              pageCross,
  output logic              done,
  output logic              crossNow
);
  localparam logic [DATA_W-1:0] ZERO_PG = '0;
  localparam logic [DATA_W-1:0] ONE_D   = DATA_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);

  logic [DATA_W-1:0] xR, yR, opLo, opHi, wLo, wHi;
  logic [ADDR_W-1:0] pcR;

  logic [DATA_W-1:0] zpX, zpY, zpX1, zpL1;
  logic [ADDR_W-1:0] absW, wordW, ptr0, ptr1;
  logic [ADDR_W-1:0] addBase, addSum, eaNext;
  logic [DATA_W-1:0] addOff;
  logic              addSigned, addCross, crossNext;

  assign zpX   = opLo + xR;
  assign zpY   = opLo + yR;
  assign zpX1  = zpX + ONE_D;
  assign zpL1  = opLo + ONE_D;
  assign absW  = {opHi, opLo};
  assign wordW = {wHi, wLo};

  // pointer addresses: page-zero modes wrap in the low byte only
  always_comb begin
    unique case (curMode)
      AM_IZX: begin
        ptr0 = {ZERO_PG, zpX};
        ptr1 = {ZERO_PG, zpX1};
      end
      AM_IZY: begin
        ptr0 = {ZERO_PG, opLo};
        ptr1 = {ZERO_PG, zpL1};
      end
      default: begin
        ptr0 = absW;
        ptr1 = absW + ONE_A;
      end
    endcase
  end

  always_comb begin
    addBase   = absW;
    addOff    = '0;
    addSigned = 1'b0;
    unique case (curMode)
      AM_ABSX: addOff = xR;
      AM_ABSY: addOff = yR;
      AM_IZY: begin
        addBase = wordW;
        addOff  = yR;
      end
      AM_REL: begin
        addBase   = pcR + ONE_A;
        addOff    = opLo;
        addSigned = 1'b1;
      end
      default: ;
    endcase
  end

  eag_off_add #(.DATA_W(DATA_W)) i_add (
    .base    (addBase),
    .offset  (addOff),
    .signExt (addSigned),
    .sum     (addSum),
    .crossed (addCross)
  );

  assign crossNow = addCross;

  always_comb begin
    crossNext = 1'b0;
    unique case (curMode)
      AM_ZP:   eaNext = {ZERO_PG, opLo};
      AM_ZPX:  eaNext = {ZERO_PG, zpX};
      AM_ZPY:  eaNext = {ZERO_PG, zpY};
      AM_ABS:  eaNext = absW;
      AM_IZX,
      AM_IND:  eaNext = wordW;
      AM_ABSX,
      AM_ABSY,
      AM_IZY,
      AM_REL: begin
        eaNext    = addSum;
        crossNext = addCross;
      end
      default: eaNext = {ZERO_PG, opLo};
    endcase
  end

  always_comb begin
    unique case (ctl.addrSel)
      SEL_PC0:  memAddr = pcR;
      SEL_PC1:  memAddr = pcR + ONE_A;
      SEL_PTR0: memAddr = ptr0;
      SEL_PTR1: memAddr = ptr1;
      default:  memAddr = pcR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xR        <= '0;
      yR        <= '0;
      pcR       <= '0;
      opLo      <= '0;
      opHi      <= '0;
      wLo       <= '0;
      wHi       <= '0;
      effAddr   <= '0;
      pageCross <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (ctl.loadCtx) begin
        xR  <= idxX;
        yR  <= idxY;
        pcR <= pcIn;
      end
      if (ctl.capOpLo) opLo <= memData;
      if (ctl.capOpHi) opHi <= memData;
      if (ctl.capWLo)  wLo  <= memData;
      if (ctl.capWHi)  wHi  <= memData;
      if (ctl.latchEa) begin
        effAddr   <= eaNext;
        pageCross <= crossNext;
      end
      done <= ctl.latchEa;
    end
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              wrAccess,
  input  logic [DATA_W-1:0] idxX,
  input  logic [DATA_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              pageCross,
  output logic              done
);
  ctl_s   ctl;
  amode_e curMode;
  logic   crossNow;

  eag_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .modeIn   (mode),
    .wrIn     (wrAccess),
    .crossNow (crossNow),
    .ctl      (ctl),
    .curMode  (curMode)
  );

  eag_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .curMode   (curMode),
    .idxX      (idxX),
    .idxY      (idxY),
    .pcIn      (pcIn),
    .memData   (memData),
    .memAddr   (memAddr),
    .effAddr   (effAddr),
    .pageCross (pageCross),
    .done      (done),
    .crossNow  (crossNow)
  );

  assign memRd = ctl.rdEn;
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [3:0]        mode,
  input logic [ADDR_W-1:0] pcIn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic [ADDR_W-1:0] effAddr,
  input logic              pageCross,
  input logic              done
);
  logic       active, accept;
  logic [3:0] trkMode, latCnt;
  logic [2:0] rdCnt;

  assign accept = start && (!active || done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      trkMode <= '0;
      latCnt  <= '0;
      rdCnt   <= '0;
    end else if (accept) begin
      active  <= 1'b1;
      trkMode <= mode;
      latCnt  <= '0;
      rdCnt   <= '0;
    end else begin
      if (done) active <= 1'b0;
      if (active && latCnt != 4'hF) latCnt <= latCnt + 4'd1;
      if (memRd && rdCnt != 3'd7) rdCnt <= rdCnt + 3'd1;
    end
  end

  // R2
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> memRd && memAddr == $past(pcIn));

  // R3
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trkMode <= 4'd2) |-> (effAddr[ADDR_W-1:DATA_W] == '0 && !pageCross));

  // R5
  abs_nocross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trkMode == 4'd3) |-> !pageCross);

  // R7
  ptr_zp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memRd && active && rdCnt != 3'd0 && (trkMode == 4'd6 || trkMode == 4'd7))
      |-> memAddr[ADDR_W-1:DATA_W] == '0);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (effAddr == $past(effAddr) && pageCross == $past(pageCross)));

  // R12
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (latCnt >= 4'd3 && latCnt <= 4'd8));
endmodule

bind eff_addr_gen eag_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mode      (mode),
  .pcIn      (pcIn),
  .memAddr   (memAddr),
  .memRd     (memRd),
  .effAddr   (effAddr),
  .pageCross (pageCross),
  .done      (done)
);

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        wrAccess = 1'b0;
  logic [7:0]  idxX = '0, idxY = '0;
  logic [15:0] pcIn = '0;
  logic [15:0] memAddr, effAddr;
  logic        memRd, pageCross, done;
  logic [7:0]  memData = '0;

  int nChk = 0, nErr = 0;
  logic [7:0]  salt = 8'h3C;
  logic        ovOn[4];
  logic [15:0] ovA[4];
  logic [7:0]  ovV[4];

  always #4 clk = ~clk;

  eff_addr_gen i_eff_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wrAccess(wrAccess),
    .idxX(idxX), .idxY(idxY), .pcIn(pcIn), .memAddr(memAddr), .memRd(memRd),
    .memData(memData), .effAddr(effAddr), .pageCross(pageCross), .done(done)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    for (int i = 0; i < 4; i++) if (ovOn[i] && ovA[i] == a) return ovV[i];
    return (a[7:0] * 8'd37) ^ a[15:8] ^ salt;
  endfunction

  // synchronous read model, one cycle latency
  always @(posedge clk) memData <= memf(memAddr);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] m);
    case (m)
      4'd0: return "R3";
      4'd1, 4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic clearOv();
    for (int i = 0; i < 4; i++) ovOn[i] = 1'b0;
  endtask

  task automatic setOv(input int i, input logic [15:0] a, input logic [7:0] v);
    ovOn[i] = 1'b1; ovA[i] = a; ovV[i] = v;
  endtask

  task automatic scramble();
    mode = 4'($urandom_range(0, 9)); idxX = 8'($urandom); idxY = 8'($urandom);
    pcIn = 16'($urandom); wrAccess = 1'($urandom);
  endtask

  task automatic runVec(input logic [3:0] m, input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] pc, input logic wr, input bit poke);
    logic [7:0]  ll, hh, p;
    logic [15:0] eaE, w, a, nx;
    logic        crE;
    int          latE, nE, nA, j;
    logic [15:0] rdE[4];
    logic [15:0] rdA[8];
    string       rq;
    rq = reqOf(m);
    ll = memf(pc); hh = memf(pc + 16'd1);
    crE = 1'b0; rdE[0] = pc; nE = 1; latE = 3;
    case (m)
      4'd0: eaE = {8'h00, ll};
      4'd1: eaE = {8'h00, 8'(ll + x)};
      4'd2: eaE = {8'h00, 8'(ll + y)};
      4'd3: begin eaE = {hh, ll}; latE = 4; rdE[1] = pc + 16'd1; nE = 2; end
      4'd4, 4'd5: begin
        eaE = {hh, ll} + {8'h00, (m == 4'd4) ? x : y};
        crE = eaE[15:8] != hh; latE = 4 + ((crE || wr) ? 1 : 0);
        rdE[1] = pc + 16'd1; nE = 2;
      end
      4'd6, 4'd7: begin
        p = (m == 4'd6) ? 8'(ll + x) : ll;
        w = {memf({8'h00, 8'(p + 8'd1)}), memf({8'h00, p})};
        rdE[1] = {8'h00, p}; rdE[2] = {8'h00, 8'(p + 8'd1)}; nE = 3; latE = 6;
        if (m == 4'd6) eaE = w;
        else begin
          eaE = w + {8'h00, y}; crE = eaE[15:8] != w[15:8];
          latE = 6 + ((crE || wr) ? 1 : 0);
        end
      end
      4'd8: begin
        a = {hh, ll}; eaE = {memf(a + 16'd1), memf(a)};
        rdE[1] = pc + 16'd1; rdE[2] = a; rdE[3] = a + 16'd1; nE = 4; latE = 7;
      end
      default: begin
        nx = pc + 16'd1; eaE = nx + {{8{ll[7]}}, ll}; crE = eaE[15:8] != nx[15:8];
      end
    endcase

    @(negedge clk);
    start = 1'b1; mode = m; idxX = x; idxY = y; pcIn = pc; wrAccess = wr;
    @(negedge clk);
    start = 1'b0; scramble();
    j = 0; nA = 0;
    while (!done && j < 20) begin
      if (memRd) begin
        if (nA < 8) rdA[nA] = memAddr;
        nA++;
      end
      @(negedge clk); j++;
      scramble();
      start = (poke && j == 1);   // R12: stray start while busy
    end
    start = 1'b0;
    if (!done) begin
      chk(1'b0, rq, "watchdog per vector", 32'(j), 32'(latE));
      return;
    end
    chk(effAddr == eaE, rq, "effAddr", 32'(effAddr), 32'(eaE));
    chk(pageCross == crE, rq, "pageCross", 32'(pageCross), 32'(crE));
    chk(j == latE, (poke ? "R12" : rq), "latency", 32'(j), 32'(latE));
    chk(nA == nE, "R2", "read count", 32'(nA), 32'(nE));
    for (int i = 0; i < nE && i < nA; i++)
      chk(rdA[i] == rdE[i], (i < 2) ? "R2" : rq, "read address", 32'(rdA[i]), 32'(rdE[i]));
    @(negedge clk);
    chk(!done, "R11", "done one clock", 32'(done), 32'd0);
    chk(effAddr == eaE && pageCross == crE, "R11", "result held",
        32'({pageCross, effAddr}), 32'({crE, eaE}));
  endtask

  initial begin
    #(200000 * 8);
    nErr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nChk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clearOv();
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !memRd && !pageCross && effAddr == 16'h0, "R1", "reset state",
        32'({done, memRd, pageCross, effAddr}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: zero page and its wrap (R3, R4)
    setOv(0, 16'h0300, 8'hF0);
    runVec(4'd0, 8'h00, 8'h00, 16'h0300, 1'b0, 1'b0);
    runVec(4'd1, 8'h20, 8'h00, 16'h0300, 1'b0, 1'b0);
    runVec(4'd2, 8'h00, 8'hFF, 16'h0300, 1'b1, 1'b0);
    // absolute and absolute indexed (R5, R6)
    setOv(0, 16'h0500, 8'h10); setOv(1, 16'h0501, 8'h30);
    runVec(4'd3, 8'h00, 8'h00, 16'h0500, 1'b1, 1'b0);
    runVec(4'd4, 8'h05, 8'h00, 16'h0500, 1'b0, 1'b0);
    runVec(4'd4, 8'hF0, 8'h00, 16'h0500, 1'b0, 1'b0);
    runVec(4'd5, 8'h00, 8'h01, 16'h0500, 1'b1, 1'b0);
    // indexed indirect wrap (R7)
    clearOv(); setOv(0, 16'h0600, 8'hFF);
    runVec(4'd6, 8'h00, 8'h00, 16'h0600, 1'b0, 1'b0);
    setOv(0, 16'h0600, 8'hFE);
    runVec(4'd6, 8'h01, 8'h00, 16'h0600, 1'b0, 1'b0);
    // indirect indexed, pointer at 0xFF with cross (R8)
    setOv(0, 16'h0600, 8'hFF); setOv(1, 16'h00FF, 8'hF0); setOv(2, 16'h0000, 8'h20);
    runVec(4'd7, 8'h00, 8'h20, 16'h0600, 1'b0, 1'b0);
    runVec(4'd7, 8'h00, 8'h01, 16'h0600, 1'b1, 1'b0);
    // absolute indirect carrying into the high byte (R9)
    clearOv(); setOv(0, 16'h0400, 8'hFF); setOv(1, 16'h0401, 8'h12);
    runVec(4'd8, 8'h00, 8'h00, 16'h0400, 1'b0, 1'b0);
    // relative, backward cross, forward no cross, forward cross (R10)
    clearOv(); setOv(0, 16'h1200, 8'h80); setOv(1, 16'h1210, 8'h05); setOv(2, 16'h12FE, 8'h01);
    runVec(4'd9, 8'h00, 8'h00, 16'h1200, 1'b0, 1'b0);
    runVec(4'd9, 8'h00, 8'h00, 16'h1210, 1'b0, 1'b0);
    runVec(4'd9, 8'h00, 8'h00, 16'h12FE, 1'b0, 1'b0);
    // stray start while busy (R12)
    runVec(4'd9, 8'h00, 8'h00, 16'h1200, 1'b0, 1'b1);
    clearOv();
    runVec(4'd8, 8'h00, 8'h00, 16'h2345, 1'b0, 1'b1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      salt = 8'($urandom);
      runVec(4'($urandom_range(0, 9)), 8'($urandom), 8'($urandom),
             16'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule